// File: doc/BRIEF.md
# Register Window Trap Entry Sequencer

This block carries out the state changes a processor with windowed registers makes when it takes a trap. A trap request arrives with an 8-bit trap type on a valid/ready handshake. When the request is accepted, the block samples the current window pointer, the supervisor bit, the trap base register and the PC/nPC pair. Over the next two cycles it moves to the previous register window and stores the old PC and nPC into that window's locals through a write port into the register file. It then presents the new control state and the handler address, together with a one-cycle done pulse.

The done pulse is the write strobe for the processor's control registers and also clears the pending trap indication. A request that is not accepted keeps waiting. `req_ready` is high only while the block is idle, so the upstream trap source is held off for the whole entry sequence, and no request is taken in the cycle of done. The `new_*` outputs are meaningful only while `done` is high. The number of windows `NWIN` must be a power of two.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `rf_we` and `done` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 during the two cycles that follow. A request offered during that time is ignored: it neither changes the outputs of the entry in progress nor starts a second entry.
- R3: In the first cycle after acceptance, `rf_we`=1 with `rf_reg`=1 and `rf_wdata` equal to the PC sampled at acceptance. In the second cycle, `rf_we`=1 with `rf_reg`=2 and `rf_wdata` equal to the sampled nPC.
- R4: `done` is 1 in the second cycle after acceptance only, and is 0 in every other cycle.
- R5: `new_cwp` equals the sampled window pointer minus one, modulo NWIN, so 0 wraps to NWIN-1. `rf_win` equals `new_cwp` whenever `rf_we` is 1.
- R6: When `done` is 1, `new_ps` equals the supervisor bit sampled at acceptance, `new_s` is 1 and `new_et` is 0.
- R7: When `done` is 1, `new_tbr` keeps bits [XLEN-1:12] of the sampled trap base register, holds the trap type in bits [11:4], and has bits [3:0] equal to 0.
- R8: When `done` is 1, `new_pc` equals `new_tbr` and `new_npc` equals `new_tbr` + 4, modulo 2^XLEN.
- R9: Changes on the `cur_*` inputs after acceptance have no effect on the values written or presented by the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Trap request offered |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_tt | input | 8 | Trap type of the offered request |
| cur_cwp | input | log2(NWIN) | Current window pointer |
| cur_s | input | 1 | Current supervisor bit |
| cur_tbr | input | XLEN | Current trap base register |
| cur_pc | input | XLEN | Current PC |
| cur_npc | input | XLEN | Current nPC |
| rf_we | output | 1 | Register file write enable |
| rf_win | output | log2(NWIN) | Window being written |
| rf_reg | output | 3 | Local register index within that window |
| rf_wdata | output | XLEN | Register file write data |
| done | output | 1 | Entry complete: commit control state and clear pending trap |
| new_cwp | output | log2(NWIN) | Window pointer after entry |
| new_s | output | 1 | Supervisor bit after entry |
| new_ps | output | 1 | Previous-supervisor bit after entry |
| new_et | output | 1 | Enable-traps bit after entry |
| new_tbr | output | XLEN | Trap base register after entry |
| new_pc | output | XLEN | Handler PC |
| new_npc | output | XLEN | Handler nPC |

## Verification
A wrong phase register shows up at once: the second local write goes missing, the same local index is written twice, or done comes one cycle early or late. All of these are visible in the cycle after acceptance or the one after that. A wrong sampled value, such as a stale PC or a window pointer taken after acceptance, shows up on `rf_wdata` or on the `new_*` buses no later than two cycles after acceptance, and the bench changes every `cur_*` input during the busy cycles so that such a fault is exposed. The window wrap and the trap type bit range are covered by directed entries at window 0, the top window, and trap types 0x00 and 0xFF with nonzero low trap base bits.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOC1 = 2'd1,
    PH_LOC2 = 2'd2
  } phase_t;

  localparam int TT_W      = 8;
  localparam int TT_LSB    = 4;
  localparam int BASE_LSB  = TT_LSB + TT_W;
  localparam logic [2:0] LOC_PC_IDX  = 3'd1;
  localparam logic [2:0] LOC_NPC_IDX = 3'd2;
endpackage

// File: rtl/trap_win_calc.sv
module trap_win_calc #(
  parameter int NWIN = 8,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [CWPW-1:0] cwp,
  output logic [CWPW-1:0] prev_cwp
);
  generate
    if (NWIN > 1) begin : g_rot
      // power-of-two window count: natural wrap of the subtractor is the modulo
      assign prev_cwp = cwp - CWPW'(1);
    end else begin : g_single
      assign prev_cwp = '0;
    end
  endgenerate
endmodule

// File: rtl/trap_tbr_build.sv
module trap_tbr_build #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]          tbr,
  input  logic [trap_pkg::TT_W-1:0] tt,
  output logic [XLEN-1:0]          tbr_new,
  output logic [XLEN-1:0]          pc_new,
  output logic [XLEN-1:0]          npc_new
);
  import trap_pkg::*;

  always_comb begin
    tbr_new = '0;
    tbr_new[XLEN-1:BASE_LSB]         = tbr[XLEN-1:BASE_LSB];
    tbr_new[BASE_LSB-1:TT_LSB]       = tt;
  end

  assign pc_new  = tbr_new;
  assign npc_new = tbr_new + XLEN'(4);
endmodule

// File: rtl/trap_seq_ctl.sv
module trap_seq_ctl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              fire,
  output trap_pkg::phase_t  phase
);
  import trap_pkg::*;

  phase_t phase_q, phase_d;

  assign req_ready = (phase_q == PH_IDLE);
  assign fire      = req_valid && req_ready;
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (fire) phase_d = PH_LOC1;
      PH_LOC1: phase_d = PH_LOC2;
      PH_LOC2: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [7:0]      req_tt,
  input  logic [CWPW-1:0] cur_cwp,
  input  logic            cur_s,
  input  logic [XLEN-1:0] cur_tbr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_npc,
  output logic            rf_we,
  output logic [CWPW-1:0] rf_win,
  output logic [2:0]      rf_reg,
  output logic [XLEN-1:0] rf_wdata,
  output logic            done,
  output logic [CWPW-1:0] new_cwp,
  output logic            new_s,
  output logic            new_ps,
  output logic            new_et,
  output logic [XLEN-1:0] new_tbr,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_npc
);
  import trap_pkg::*;

  phase_t          phase;
  logic            fire;

  // state sampled at acceptance
  logic [TT_W-1:0] tt_q;
  logic [CWPW-1:0] cwp_q;
  logic            s_q;
  logic [XLEN-1:0] tbr_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] npc_q;

  trap_seq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .fire      (fire),
    .phase     (phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tt_q  <= '0;
      cwp_q <= '0;
      s_q   <= 1'b0;
      tbr_q <= '0;
      pc_q  <= '0;
      npc_q <= '0;
    end else if (fire) begin
      tt_q  <= req_tt;
      cwp_q <= cur_cwp;
      s_q   <= cur_s;
      tbr_q <= cur_tbr;
      pc_q  <= cur_pc;
      npc_q <= cur_npc;
    end
  end

  trap_win_calc #(.NWIN(NWIN)) u_win (
    .cwp      (cwp_q),
    .prev_cwp (new_cwp)
  );

  trap_tbr_build #(.XLEN(XLEN)) u_tbr (
    .tbr     (tbr_q),
    .tt      (tt_q),
    .tbr_new (new_tbr),
    .pc_new  (new_pc),
    .npc_new (new_npc)
  );

  // register file port: old PC into first local slot, old nPC into second
  always_comb begin
    rf_we    = 1'b0;
    rf_reg   = LOC_PC_IDX;
    rf_wdata = pc_q;
    unique case (phase)
      PH_LOC1: begin
        rf_we    = 1'b1;
        rf_reg   = LOC_PC_IDX;
        rf_wdata = pc_q;
      end
      PH_LOC2: begin
        rf_we    = 1'b1;
        rf_reg   = LOC_NPC_IDX;
        rf_wdata = npc_q;
      end
      default: ;
    endcase
  end

  assign rf_win = new_cwp;
  assign done   = (phase == PH_LOC2);
  assign new_s  = 1'b1;
  assign new_ps = s_q;
  assign new_et = 1'b0;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CWPW-1:0] cur_cwp,
  input logic            cur_s,
  input logic            rf_we,
  input logic [CWPW-1:0] rf_win,
  input logic [2:0]      rf_reg,
  input logic            done,
  input logic [CWPW-1:0] new_cwp,
  input logic            new_ps,
  input logic [XLEN-1:0] new_pc,
  input logic [XLEN-1:0] new_npc
);
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_DONE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready, 2) |-> done); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rf_we && rf_reg == 3'd2)); // R3
  AST_WIN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_win == new_cwp)); // R5
  AST_WIN_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready, 2) |-> (new_cwp == CWPW'($past(cur_cwp, 2) - CWPW'(1)))); // R5
  AST_PREV_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready, 2) |-> (new_ps == $past(cur_s, 2))); // R6
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_npc == new_pc + XLEN'(4))); // R8
endmodule

bind trap_entry_seq trap_entry_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cur_cwp   (cur_cwp),
  .cur_s     (cur_s),
  .rf_we     (rf_we),
  .rf_win    (rf_win),
  .rf_reg    (rf_reg),
  .done      (done),
  .new_cwp   (new_cwp),
  .new_ps    (new_ps),
  .new_pc    (new_pc),
  .new_npc   (new_npc)
);

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int CWPW = $clog2(NWIN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [7:0]      req_tt = '0;
  logic [CWPW-1:0] cur_cwp = '0;
  logic            cur_s = 1'b0;
  logic [XLEN-1:0] cur_tbr = '0;
  logic [XLEN-1:0] cur_pc = '0;
  logic [XLEN-1:0] cur_npc = '0;
  logic            rf_we;
  logic [CWPW-1:0] rf_win;
  logic [2:0]      rf_reg;
  logic [XLEN-1:0] rf_wdata;
  logic            done;
  logic [CWPW-1:0] new_cwp;
  logic            new_s, new_ps, new_et;
  logic [XLEN-1:0] new_tbr, new_pc, new_npc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tt(req_tt), .cur_cwp(cur_cwp), .cur_s(cur_s), .cur_tbr(cur_tbr),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .rf_we(rf_we), .rf_win(rf_win),
    .rf_reg(rf_reg), .rf_wdata(rf_wdata), .done(done), .new_cwp(new_cwp),
    .new_s(new_s), .new_ps(new_ps), .new_et(new_et), .new_tbr(new_tbr),
    .new_pc(new_pc), .new_npc(new_npc)
  );

  function automatic logic [XLEN-1:0] exp_tbr(logic [XLEN-1:0] tbr, logic [7:0] tt);
    return (tbr & ~XLEN'(32'hFFF)) | (XLEN'(tt) << 4);
  endfunction

  function automatic logic [CWPW-1:0] exp_win(logic [CWPW-1:0] w);
    return (w == 0) ? CWPW'(NWIN - 1) : CWPW'(w - 1);
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full entry; inputs scrambled and a bogus request offered while busy
  task automatic run_trap(logic [7:0] tt, logic [CWPW-1:0] w, logic s,
                          logic [XLEN-1:0] tbr, logic [XLEN-1:0] pc,
                          logic [XLEN-1:0] npc);
    logic [XLEN-1:0] et;
    et = exp_tbr(tbr, tt);
    // at a negedge with the block idle
    chk("R2 ready idle", XLEN'(req_ready), 1);
    req_valid = 1'b1; req_tt = tt; cur_cwp = w; cur_s = s;
    cur_tbr = tbr; cur_pc = pc; cur_npc = npc;
    @(negedge clk);
    // first cycle after acceptance
    chk("R2 ready busy", XLEN'(req_ready), 0);
    chk("R3 we1", XLEN'(rf_we), 1);
    chk("R3 idx1", XLEN'(rf_reg), 1);
    chk("R3 pc data", rf_wdata, pc);
    chk("R5 win1", XLEN'(rf_win), XLEN'(exp_win(w)));
    chk("R4 no early done", XLEN'(done), 0);
    // R2/R9: new request and changed inputs while busy
    req_tt = ~tt; cur_cwp = ~w; cur_s = ~s; cur_tbr = ~tbr;
    cur_pc = ~pc; cur_npc = ~npc;
    @(negedge clk);
    chk("R2 ready busy2", XLEN'(req_ready), 0);
    chk("R3 we2", XLEN'(rf_we), 1);
    chk("R3 idx2", XLEN'(rf_reg), 2);
    chk("R9 npc data", rf_wdata, npc);
    chk("R4 done", XLEN'(done), 1);
    chk("R5 new_cwp", XLEN'(new_cwp), XLEN'(exp_win(w)));
    chk("R5 win2", XLEN'(rf_win), XLEN'(exp_win(w)));
    chk("R6 ps", XLEN'(new_ps), XLEN'(s));
    chk("R6 s", XLEN'(new_s), 1);
    chk("R6 et", XLEN'(new_et), 0);
    chk("R7 tbr", new_tbr, et);
    chk("R8 pc", new_pc, et);
    chk("R8 npc", new_npc, et + XLEN'(4));
    req_valid = 1'b0;
    @(negedge clk);
    chk("R4 done single", XLEN'(done), 0);
    chk("R2 no second entry", XLEN'(rf_we), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 ready", XLEN'(req_ready), 1);
    chk("R1 we", XLEN'(rf_we), 0);
    chk("R1 done", XLEN'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done", XLEN'(done), 0);
    // directed corners
    run_trap(8'h00, CWPW'(0), 1'b0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_1004);
    run_trap(8'hFF, CWPW'(NWIN - 1), 1'b1, 32'h4000_0ABC, 32'hDEAD_BEE0, 32'hDEAD_BEE4);
    run_trap(8'h5A, CWPW'(1), 1'b1, 32'hFFFF_F000, 32'h8000_0000, 32'h8000_0004);
    for (int i = 0; i < 60; i++) begin
      logic [7:0] rtt;
      logic [CWPW-1:0] rw;
      rtt = 8'($urandom);
      rw = CWPW'($urandom);
      run_trap(rtt, rw, 1'($urandom), $urandom, $urandom, $urandom);
      if ($urandom % 3 == 0) begin
        // idle gap: no request, nothing written
        @(negedge clk);
        chk("R2 idle no write", XLEN'(rf_we), 0);
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule